// File: doc/BRIEF.md
# BCD Calendar Clock Register Core

This block keeps the time of day and the calendar date as packed BCD bytes. It holds seconds, minutes, hours, day of month, month, a two-digit year and a weekday. A base tick input is divided down to one-second steps by an internal phase counter, and every second step advances the calendar with full rollover. The rollover covers month lengths and leap years. Hours count in either 24-hour or 12-hour form.

Software reaches the block through a byte-wide register port. A write lands in the same cycle it is presented, and a read returns data combinationally from the address, so there is no handshake and no back-pressure. Time fields read back from a shadow copy. The shadow copy is refreshed only when software requests a snapshot through the control register. As a result, a read of all seven bytes always describes one instant, even while counting continues underneath.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the time fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, weekday 0x00. The control register (address 0x0D) reads 0x00 and the status register (address 0x0E) reads 0x00, so the clock is stopped.
- R2: Seconds and minutes count in packed BCD. Each wraps from 0x59 to 0x00, and a seconds wrap advances minutes.
- R3: In 24-hour mode (control bit 3 clear), hours wrap from 0x23 to 0x00, and that wrap advances the day.
- R4: In 12-hour mode (control bit 3 set), hours bits 4:0 hold BCD 01 to 12 and bit 7 is the PM flag. The sequence is 11 to 12 with the PM flag toggled, 12 to 01 with the flag kept, and otherwise a plain BCD increment. Only the step from 11 PM to 12 AM advances the day.
- R5: Day wraps to 0x01 after the last day of the month and advances the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days. Month wraps from 0x12 to 0x01 and advances the year. Year wraps from 0x99 to 0x00.
- R6: Weekday counts 0 to 6 and advances on every day rollover, wrapping from 6 to 0.
- R7: Control bit 0 runs the clock. While it is clear, base ticks are ignored and no field changes. Status bit 1 reads back the run state.
- R8: Writing control with bit 6 set copies all seven live fields into the read-back copy one cycle later. Bit 6 then clears itself and reads 0.
- R9: A write to any time field loads the value and restarts the sub-second phase. The next second step therefore comes TICKS_PER_SEC running ticks after the write.
- R10: Time fields sit at addresses 0x00 to 0x06 in the order seconds, minutes, hours, day, month, year, weekday. Unmapped addresses read 0x00.
- R11: Without a new snapshot request, the read-back copy does not change while the live calendar keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Sub-second tick enable; TICKS_PER_SEC of them make one second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The hardest states to reach from the ports are the rare rollovers: the last day of each month in leap and non-leap years, the December wrap into the next year, and the 11 PM step in 12-hour mode. Letting the clock run into these states would take far too long. The stimulus instead stops the clock, writes a moment one second before each boundary, restarts the clock, and feeds exactly one second of ticks. It then takes a snapshot and compares every field against values the bench computes arithmetically. This is swept over all twelve months for four years, all 24 hours in both hour formats, and every weekday value.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
    logic [7:0] wday;
  } cal_t;

  localparam int NUM_FIELDS = 7;
  localparam logic [3:0] ADR_CTRL = 4'hD;
  localparam logic [3:0] ADR_STAT = 4'hE;
  localparam int CTL_RUN  = 0;
  localparam int CTL_H12  = 3;
  localparam int CTL_SNAP = 6;
  localparam int STA_RUN  = 1;

  localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                 day: 8'h01, mon: 8'h01, year: 8'h00,
                                 wday: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] x);
    if (x[3:0] == 4'h9) return {x[7:4] + 4'h1, 4'h0};
    return {x[7:4], x[3:0] + 4'h1};
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    logic [7:0] bin;
    bin = ({4'h0, y[7:4]} * 8'd10) + {4'h0, y[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02: return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_cal_prescale.sv
module bcd_cal_prescale #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic base_tick,
  input  logic phase_clr,
  output logic sec_step
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] phase_q;

  assign sec_step = run && base_tick && !phase_clr && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else if (phase_clr) phase_q <= '0;
    else if (run && base_tick) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !phase_clr) |=> $stable(phase_q)); // R7
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> (phase_q == '0)); // R9
endmodule

// File: rtl/bcd_cal_counter.sv
module bcd_cal_counter
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       mode12,
  input  logic       ld_en,
  input  logic [2:0] ld_idx,
  input  logic [7:0] ld_data,
  output cal_t       cal
);
  cal_t cal_q;
  cal_t nxt;
  logic sec_wrap, min_wrap, hour_day, day_wrap, mon_wrap;
  logic adv_min, adv_hour, adv_day, adv_mon, adv_year;
  logic [4:0] h12;
  logic       pm;

  assign cal = cal_q;

  always_comb begin
    nxt      = cal_q;
    sec_wrap = (cal_q.sec == 8'h59);
    min_wrap = (cal_q.min == 8'h59);
    day_wrap = (cal_q.day >= last_day(cal_q.mon, cal_q.year));
    mon_wrap = (cal_q.mon >= 8'h12);
    h12      = cal_q.hour[4:0];
    pm       = cal_q.hour[7];
    hour_day = 1'b0;

    nxt.sec = sec_wrap ? 8'h00 : bcd_inc(cal_q.sec);
    nxt.min = min_wrap ? 8'h00 : bcd_inc(cal_q.min);

    if (mode12) begin
      if (h12 == 5'h11) begin
        nxt.hour = {~pm, 2'b00, 5'h12};
        hour_day = pm;
      end else if (h12 == 5'h12) begin
        nxt.hour = {pm, 2'b00, 5'h01};
      end else if (h12[3:0] == 4'h9) begin
        nxt.hour = {pm, 2'b00, 5'h10};
      end else begin
        nxt.hour = {pm, 2'b00, h12[4], h12[3:0] + 4'h1};
      end
    end else begin
      if (cal_q.hour == 8'h23) begin
        nxt.hour = 8'h00;
        hour_day = 1'b1;
      end else begin
        nxt.hour = bcd_inc(cal_q.hour);
      end
    end

    nxt.day  = day_wrap ? 8'h01 : bcd_inc(cal_q.day);
    nxt.mon  = mon_wrap ? 8'h01 : bcd_inc(cal_q.mon);
    nxt.year = (cal_q.year == 8'h99) ? 8'h00 : bcd_inc(cal_q.year);
    nxt.wday = (cal_q.wday >= 8'd6) ? 8'd0 : cal_q.wday + 8'd1;

    adv_min  = sec_wrap;
    adv_hour = adv_min && min_wrap;
    adv_day  = adv_hour && hour_day;
    adv_mon  = adv_day && day_wrap;
    adv_year = adv_mon && mon_wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_q <= CAL_RESET;
    end else if (ld_en) begin
      case (ld_idx)
        3'd0: cal_q.sec  <= ld_data;
        3'd1: cal_q.min  <= ld_data;
        3'd2: cal_q.hour <= ld_data;
        3'd3: cal_q.day  <= ld_data;
        3'd4: cal_q.mon  <= ld_data;
        3'd5: cal_q.year <= ld_data;
        default: cal_q.wday <= ld_data;
      endcase
    end else if (step) begin
      cal_q.sec <= nxt.sec;
      if (adv_min)  cal_q.min  <= nxt.min;
      if (adv_hour) cal_q.hour <= nxt.hour;
      if (adv_day) begin
        cal_q.day  <= nxt.day;
        cal_q.wday <= nxt.wday;
      end
      if (adv_mon)  cal_q.mon  <= nxt.mon;
      if (adv_year) cal_q.year <= nxt.year;
    end
  end

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_en) |=> $stable(cal_q)); // R7
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_en && cal_q.sec == 8'h59) |=> (cal_q.sec == 8'h00)); // R2
  AST_MONTH_NEEDS_DAY1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && step) |=> ($stable(cal_q.mon) || cal_q.day == 8'h01)); // R5
  AST_WDAY_WITH_DAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && $stable(cal_q.day)) |=> $stable(cal_q.wday) || $past(ld_en) || !$stable(cal_q.day)); // R6
endmodule

// File: rtl/bcd_cal_shadow.sv
module bcd_cal_shadow
  import bcd_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  cal_t live,
  output cal_t held
);
  cal_t held_q;
  assign held = held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= CAL_RESET;
    else if (capture) held_q <= live;
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (held_q == $past(live))); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(held_q)); // R11
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import bcd_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_NF   = ADDR_W'(NUM_FIELDS);

  logic run_q, h12_q, snap_q;
  logic field_wr, ctrl_wr, sec_step;
  cal_t live, held;

  assign field_wr = bus_wr && (bus_addr < A_NF);
  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      h12_q  <= 1'b0;
      snap_q <= 1'b0;
    end else if (ctrl_wr) begin
      run_q  <= bus_wdata[CTL_RUN];
      h12_q  <= bus_wdata[CTL_H12];
      snap_q <= bus_wdata[CTL_SNAP];
    end else begin
      snap_q <= 1'b0;
    end
  end

  bcd_cal_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .base_tick(base_tick),
    .phase_clr(field_wr), .sec_step(sec_step));

  bcd_cal_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .step(sec_step), .mode12(h12_q),
    .ld_en(field_wr), .ld_idx(bus_addr[2:0]), .ld_data(bus_wdata), .cal(live));

  bcd_cal_shadow u_shd (
    .clk(clk), .rst_n(rst_n), .capture(snap_q), .live(live), .held(held));

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == A_CTRL) begin
      bus_rdata[CTL_RUN]  = run_q;
      bus_rdata[CTL_H12]  = h12_q;
      bus_rdata[CTL_SNAP] = snap_q;
    end else if (bus_addr == A_STAT) begin
      bus_rdata[STA_RUN] = run_q;
    end else if (bus_addr < A_NF) begin
      case (bus_addr[2:0])
        3'd0: bus_rdata = held.sec;
        3'd1: bus_rdata = held.min;
        3'd2: bus_rdata = held.hour;
        3'd3: bus_rdata = held.day;
        3'd4: bus_rdata = held.mon;
        3'd5: bus_rdata = held.year;
        default: bus_rdata = held.wday;
      endcase
    end
  end

  AST_SNAP_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_q && !ctrl_wr) |=> !snap_q); // R8
  AST_NO_STEP_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !sec_step); // R7
endmodule

// File: tb/bcd_calendar_core_tb.sv
module bcd_calendar_core_tb;
  localparam int TPS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_tick = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] got [0:6];
  logic mode12 = 1'b0;

  always #2 clk = ~clk;

  bcd_calendar_core #(.TICKS_PER_SEC(TPS), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] enc12(input int h24);
    int h;
    h = (h24 % 12 == 0) ? 12 : h24 % 12;
    return {(h24 >= 12) ? 1'b1 : 1'b0, 2'b00, bcd(h)[4:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_ctrl(input bit run, input bit snap);
    wr(4'hD, {1'b0, snap, 2'b00, mode12, 2'b00, run});
  endtask

  task automatic snap_all(input bit run);
    set_ctrl(run, 1'b1);
    @(negedge clk);
    for (int i = 0; i < 7; i++) rd(4'(i), got[i]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); base_tick = 1'b1;
      @(negedge clk); base_tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo, y, w);
    set_ctrl(1'b0, 1'b0);
    wr(4'h0, s); wr(4'h1, m); wr(4'h2, h); wr(4'h3, d);
    wr(4'h4, mo); wr(4'h5, y); wr(4'h6, w);
    set_ctrl(1'b1, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 field order
    for (int i = 0; i < 7; i++) begin
      rd(4'(i), v);
      chk("R1 reset field", v, (i == 3 || i == 4) ? 8'h01 : 8'h00);
    end
    rd(4'hD, v); chk("R1 ctrl", v, 8'h00);
    rd(4'hE, v); chk("R1 status", v, 8'h00);
    rd(4'h8, v); chk("R10 unmapped", v, 8'h00);
    rd(4'hF, v); chk("R10 unmapped", v, 8'h00);

    // R7 stopped clock ignores ticks
    ticks(6);
    snap_all(1'b0);
    chk("R7 stopped sec", got[0], 8'h00);

    // R2 seconds/minutes counting sweep
    set_ctrl(1'b1, 1'b0);
    rd(4'hE, v); chk("R7 status run", v, 8'h02);
    for (int s = 1; s <= 75; s++) begin
      ticks(TPS);
      snap_all(1'b1);
      chk("R2 sec", got[0], bcd(s % 60));
      chk("R2 min", got[1], bcd(s / 60));
    end
    set_time(8'h59, 8'h59, 8'h05, 8'h10, 8'h03, 8'h30, 8'h02);
    ticks(TPS);
    snap_all(1'b1);
    chk("R2 min wrap", got[1], 8'h00);
    chk("R2 hour carry", got[2], 8'h06);

    // R3 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      set_time(8'h59, 8'h59, bcd(h), 8'h15, 8'h05, 8'h24, 8'h03);
      ticks(TPS);
      snap_all(1'b1);
      chk("R3 hour", got[2], bcd((h + 1) % 24));
      chk("R3 day", got[3], (h == 23) ? 8'h16 : 8'h15);
    end

    // R4 12-hour sweep
    mode12 = 1'b1;
    for (int h = 0; h < 24; h++) begin
      set_time(8'h59, 8'h59, enc12(h), 8'h15, 8'h05, 8'h24, 8'h03);
      ticks(TPS);
      snap_all(1'b1);
      chk("R4 hour12", got[2], enc12((h + 1) % 24));
      chk("R4 day", got[3], (h == 23) ? 8'h16 : 8'h15);
    end
    mode12 = 1'b0;

    // R5 R6 month-end sweep over leap and non-leap years
    for (int yi = 0; yi < 4; yi++) begin
      int y;
      y = (yi == 0) ? 23 : (yi == 1) ? 24 : (yi == 2) ? 0 : 99;
      for (int m = 1; m <= 12; m++) begin
        int w;
        w = m % 7;
        set_time(8'h59, 8'h59, 8'h23, bcd(dim(m, y)), bcd(m), bcd(y), bcd(w));
        ticks(TPS);
        snap_all(1'b1);
        chk("R5 day", got[3], 8'h01);
        chk("R5 month", got[4], bcd((m == 12) ? 1 : m + 1));
        chk("R5 year", got[5], bcd((m == 12) ? (y + 1) % 100 : y));
        chk("R6 weekday", got[6], bcd((w + 1) % 7));
        chk("R3 hour wrap", got[2], 8'h00);
      end
    end
    // R5 day before the end does not wrap (Feb 28 in leap year)
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h00);
    ticks(TPS);
    snap_all(1'b1);
    chk("R5 leap feb29", got[3], 8'h29);
    chk("R5 leap month", got[4], 8'h02);

    // R8 snapshot bit self-clears
    rd(4'hD, v); chk("R8 snap cleared", v, 8'h01);

    // R11 held copy stable while counting
    set_time(8'h10, 8'h20, 8'h08, 8'h05, 8'h06, 8'h40, 8'h01);
    snap_all(1'b1);
    chk("R8 captured sec", got[0], 8'h10);
    ticks(3 * TPS);
    rd(4'h0, v); chk("R11 held sec", v, 8'h10);
    snap_all(1'b1);
    chk("R11 refreshed sec", got[0], 8'h13);

    // R9 field write restarts sub-second phase
    ticks(1);
    wr(4'h0, 8'h30);
    ticks(1);
    snap_all(1'b1);
    chk("R9 no early step", got[0], 8'h30);
    ticks(1);
    snap_all(1'b1);
    chk("R9 step after full phase", got[0], 8'h31);

    // R7 stop freezes
    set_ctrl(1'b0, 1'b0);
    rd(4'hE, v); chk("R7 status stopped", v, 8'h00);
    ticks(4 * TPS);
    snap_all(1'b0);
    chk("R7 frozen sec", got[0], 8'h31);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule